// File: doc/BRIEF.md
# Error-Triggered Retry and Cycle-Stretch Controller

This block sits behind a temporal error detector and turns its error flag into a recovery sequence. It runs on a fast reference clock. A built-in cycle generator issues a one-tick clock-enable strobe that marks the end of each functional cycle. The detector's flag is judged only on that strobe.

The first error starts a replay at the nominal cycle length. This clears a transient upset. If the replay also reports an error, the fault is taken to be a timing error. The next replay then runs with every cycle lengthened by a parameterised number of reference ticks, which the integrator sets to at least the detection window. After a successful lengthened replay, a configurable number of further cycles stay lengthened before the nominal length returns. An error during the lengthened replay is final: the controller parks in a sticky failure state that only reset leaves.

The upstream pipeline gets a hold/replay level. The external clock generator gets the strobe and a lengthened-cycle flag. A saturating retry counter and the failure flag are exposed as well.

Top module: `rcs_retry_ctrl`

## Requirements
- R1: While reset is active and right after it is released, hold_o, fail_o and stretch_o are 0 and retry_cnt_o is 0.
- R2: With no error, cyc_en_o is high for exactly one reference tick in every BASE_TICKS ticks. hold_o and stretch_o stay low.
- R3: err_i is only sampled on a tick where cyc_en_o is high. An error pulse that ends before that tick has no effect on hold_o, stretch_o or retry_cnt_o.
- R4: An error seen while idle starts a retry cycle of nominal length (BASE_TICKS). During that cycle hold_o is 1 and stretch_o is 0, and retry_cnt_o has grown by one.
- R5: If the nominal retry ends without error, hold_o returns to 0 at that cycle boundary, and the next cycle has nominal length.
- R6: An error at the end of a nominal retry starts a retry cycle of BASE_TICKS+DELTA_TICKS ticks. During that cycle hold_o and stretch_o are 1, and retry_cnt_o has grown by one.
- R7: After a clean stretched retry, hold_o drops at the boundary. The next STRETCH_HOLD cycles are still BASE_TICKS+DELTA_TICKS long with stretch_o high. After them the nominal length returns.
- R8: An error at the end of a stretched retry sets fail_o. From then until reset, fail_o, hold_o and stretch_o stay 1, cycles stay lengthened, and further errors leave retry_cnt_o unchanged.
- R9: retry_cnt_o counts every retry started. It saturates at 2^CNT_W-1 instead of wrapping.
- R10: An error during the post-recovery lengthened window starts a nominal-length retry and cancels the rest of the window.
- R11: hold_o, stretch_o, fail_o and retry_cnt_o change only on the tick that follows a cyc_en_o strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| err_i | input | 1 | Error flag from the temporal detector, valid on strobe ticks |
| cyc_en_o | output | 1 | One-tick clock-enable strobe ending each functional cycle |
| stretch_o | output | 1 | The cycle in progress is lengthened |
| hold_o | output | 1 | Hold/replay request to the upstream pipeline |
| fail_o | output | 1 | Sticky unrecoverable-fault flag |
| retry_cnt_o | output | CNT_W | Saturating count of retries started |

## Verification
Some rules are checked on every tick by the assertions:
- the strobe never lasts more than one tick;
- the status outputs move only at cycle boundaries;
- a nominal retry that fails escalates to a stretched one;
- the failure state is sticky and keeps hold raised;
- the retry count neither wraps nor skips.

Other behaviour only shows up over whole scenarios, and the bench checks it by measuring cycle lengths in reference ticks. This covers the exact escalation order, the length and the cancellation of the post-recovery stretch window, saturation of the count, and the fact that a glitch on the error flag between boundaries is ignored.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // Recovery phases; the order of escalation is IDLE -> NOM -> STR -> FAIL
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RETRY_NOM = 2'd1,
        ST_RETRY_STR = 2'd2,
        ST_FAIL      = 2'd3
    } rcs_state_e;

endpackage

// File: rtl/rcs_cycle_gen.sv
module rcs_cycle_gen #(
    parameter int BASE_TICKS  = 8,
    parameter int DELTA_TICKS = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stretch_next_i,
    output logic cyc_en_o,
    output logic stretch_o
);

    localparam int LONG_TICKS = BASE_TICKS + DELTA_TICKS;
    localparam int CW         = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LOAD_BASE = CW'(BASE_TICKS - 1);
    localparam logic [CW-1:0] LOAD_LONG = CW'(LONG_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stretch;
    } gen_reg_t;

    gen_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == '0) begin
            // boundary: the length of the coming cycle is fixed here
            r_d.stretch = stretch_next_i;
            r_d.cnt     = stretch_next_i ? LOAD_LONG : LOAD_BASE;
        end else begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.cnt     <= LOAD_BASE;
            r_q.stretch <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cyc_en_o  = (r_q.cnt == '0);
    assign stretch_o = r_q.stretch;

    AST_SINGLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_en_o |=> !cyc_en_o);  // R2

endmodule

// File: rtl/rcs_recovery_fsm.sv
module rcs_recovery_fsm
    import rcs_pkg::*;
#(
    parameter int STRETCH_HOLD = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       boundary_i,
    input  logic       err_i,
    output rcs_state_e state_o,
    output logic       retry_inc_o,
    output logic       stretch_next_o
);

    localparam int HW = $clog2(STRETCH_HOLD + 2);
    localparam logic [HW-1:0] WIN_LOAD = HW'(STRETCH_HOLD);

    typedef struct packed {
        rcs_state_e    state;
        logic [HW-1:0] win;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;
    logic     inc_d;

    always_comb begin
        r_d   = r_q;
        inc_d = 1'b0;
        if (boundary_i) begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (err_i) begin
                        r_d.state = ST_RETRY_NOM;
                        r_d.win   = '0;
                        inc_d     = 1'b1;
                    end else if (r_q.win != '0) begin
                        r_d.win = r_q.win - 1'b1;
                    end
                end
                ST_RETRY_NOM: begin
                    if (err_i) begin
                        r_d.state = ST_RETRY_STR;
                        inc_d     = 1'b1;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
                ST_RETRY_STR: begin
                    if (err_i) begin
                        r_d.state = ST_FAIL;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.win   = WIN_LOAD;
                    end
                end
                default: r_d.state = ST_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.win   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o        = r_q.state;
    assign retry_inc_o    = inc_d;
    assign stretch_next_o = (r_d.state == ST_RETRY_STR) || (r_d.state == ST_FAIL) ||
                            ((r_d.state == ST_IDLE) && (r_d.win != '0));

    AST_ESCALATE_TO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (boundary_i && err_i && r_q.state == ST_RETRY_NOM) |=> (r_q.state == ST_RETRY_STR));  // R6
    AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_FAIL) |=> (r_q.state == ST_FAIL));  // R8
    AST_QUIET_BETWEEN_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boundary_i |=> $stable(r_q));  // R3

endmodule

// File: rtl/rcs_retry_counter.sv
module rcs_retry_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));  // R9
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));  // R9

endmodule

// File: rtl/rcs_retry_ctrl.sv
module rcs_retry_ctrl
    import rcs_pkg::*;
#(
    parameter int BASE_TICKS   = 8,
    parameter int DELTA_TICKS  = 2,
    parameter int STRETCH_HOLD = 4,
    parameter int CNT_W        = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             err_i,
    output logic             cyc_en_o,
    output logic             stretch_o,
    output logic             hold_o,
    output logic             fail_o,
    output logic [CNT_W-1:0] retry_cnt_o
);

    rcs_state_e state;
    logic       boundary;
    logic       retry_inc;
    logic       stretch_next;

    rcs_cycle_gen #(
        .BASE_TICKS (BASE_TICKS),
        .DELTA_TICKS(DELTA_TICKS)
    ) u_gen (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .stretch_next_i(stretch_next),
        .cyc_en_o      (boundary),
        .stretch_o     (stretch_o)
    );

    rcs_recovery_fsm #(
        .STRETCH_HOLD(STRETCH_HOLD)
    ) u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .boundary_i    (boundary),
        .err_i         (err_i),
        .state_o       (state),
        .retry_inc_o   (retry_inc),
        .stretch_next_o(stretch_next)
    );

    rcs_retry_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (retry_inc),
        .cnt_o (retry_cnt_o)
    );

    assign cyc_en_o = boundary;
    assign hold_o   = (state != ST_IDLE);
    assign fail_o   = (state == ST_FAIL);

    AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_en_o |=> $stable(hold_o));  // R11
    AST_STRETCH_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_en_o |=> $stable(stretch_o));  // R11
    AST_COUNT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_en_o |=> $stable(retry_cnt_o));  // R11
    AST_FAIL_KEEPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |-> (hold_o && stretch_o));  // R8

endmodule

// File: tb/rcs_retry_ctrl_tb.sv
module rcs_retry_ctrl_tb;

    localparam int BASE  = 4;
    localparam int DELTA = 2;
    localparam int SHOLD = 2;
    localparam int CW    = 3;
    localparam int LONG  = BASE + DELTA;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err = 1'b0;
    logic          cyc_en, stretch, hold, fail;
    logic [CW-1:0] rcnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rcs_retry_ctrl #(
        .BASE_TICKS  (BASE),
        .DELTA_TICKS (DELTA),
        .STRETCH_HOLD(SHOLD),
        .CNT_W       (CW)
    ) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .err_i      (err),
        .cyc_en_o   (cyc_en),
        .stretch_o  (stretch),
        .hold_o     (hold),
        .fail_o     (fail),
        .retry_cnt_o(rcnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Run one functional cycle with err driven for its boundary; starts at the
    // negedge where the previous strobe was seen. Checks the cycle's outputs.
    task automatic cyc(input logic e, input string tag, input int exp_len,
                       input int exp_h, input int exp_s, input int exp_f, input int exp_c);
        int len;
        @(posedge clk);
        #1 err = e;
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!cyc_en);
        chk({tag, " length"}, len, exp_len);
        chk({tag, " hold"}, int'(hold), exp_h);
        chk({tag, " stretch"}, int'(stretch), exp_s);
        chk({tag, " fail"}, int'(fail), exp_f);
        chk({tag, " count"}, int'(rcnt), exp_c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        err   = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 hold in reset", int'(hold), 0);
        chk("R1 fail in reset", int'(fail), 0);
        chk("R1 stretch in reset", int'(stretch), 0);
        chk("R1 count in reset", int'(rcnt), 0);
        rst_n = 1'b1;
        do @(negedge clk); while (!cyc_en);
        chk("R1 hold after reset", int'(hold), 0);
        chk("R1 count after reset", int'(rcnt), 0);
    endtask

    initial begin
        do_reset();

        // R2: error-free cycles at nominal length
        for (int i = 0; i < 3; i++) cyc(1'b0, "R2 idle", BASE, 0, 0, 0, 0);

        // R3: glitch on err that ends before the strobe
        @(posedge clk);
        #1 err = 1'b1;
        @(negedge clk);
        @(negedge clk);
        err = 1'b0;
        do @(negedge clk); while (!cyc_en);
        cyc(1'b0, "R3 glitch ignored", BASE, 0, 0, 0, 0);

        // R4/R5: transient error healed by nominal retry
        cyc(1'b1, "R4 erroneous op", BASE, 0, 0, 0, 0);
        cyc(1'b0, "R4 nominal retry", BASE, 1, 0, 0, 1);
        cyc(1'b0, "R5 back to idle", BASE, 0, 0, 0, 1);

        // R6/R7: persistent error healed by stretched retry
        cyc(1'b1, "R6 erroneous op", BASE, 0, 0, 0, 1);
        cyc(1'b1, "R6 nominal retry fails", BASE, 1, 0, 0, 2);
        cyc(1'b0, "R6 stretched retry", LONG, 1, 1, 0, 3);
        for (int i = 0; i < SHOLD; i++) cyc(1'b0, "R7 stretch window", LONG, 0, 1, 0, 3);
        cyc(1'b0, "R7 nominal restored", BASE, 0, 0, 0, 3);

        // R10: error inside the post-recovery window
        cyc(1'b1, "R10 erroneous op", BASE, 0, 0, 0, 3);
        cyc(1'b1, "R10 nominal retry fails", BASE, 1, 0, 0, 4);
        cyc(1'b0, "R10 stretched retry", LONG, 1, 1, 0, 5);
        cyc(1'b1, "R10 error in window", LONG, 0, 1, 0, 5);
        cyc(1'b0, "R10 nominal retry", BASE, 1, 0, 0, 6);
        cyc(1'b0, "R10 window cancelled", BASE, 0, 0, 0, 6);

        // R9: saturation of the retry count
        cyc(1'b1, "R9 erroneous op", BASE, 0, 0, 0, 6);
        cyc(1'b0, "R9 retry to max", BASE, 1, 0, 0, CMAX);
        cyc(1'b1, "R9 erroneous op", BASE, 0, 0, 0, CMAX);
        cyc(1'b0, "R9 retry saturated", BASE, 1, 0, 0, CMAX);
        cyc(1'b0, "R9 idle", BASE, 0, 0, 0, CMAX);

        // R8: permanent fault reaches the failure state
        do_reset();
        cyc(1'b1, "R8 erroneous op", BASE, 0, 0, 0, 0);
        cyc(1'b1, "R8 nominal retry fails", BASE, 1, 0, 0, 1);
        cyc(1'b1, "R8 stretched retry fails", LONG, 1, 1, 0, 2);
        cyc(1'b0, "R8 failed", LONG, 1, 1, 1, 2);
        cyc(1'b1, "R8 error ignored", LONG, 1, 1, 1, 2);
        cyc(1'b0, "R8 still failed", LONG, 1, 1, 1, 2);

        // R1: reset leaves the failure state
        do_reset();
        cyc(1'b0, "R1 nominal after reset", BASE, 0, 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule